// File: doc/BRIEF.md
# Chip-Select-Gated Command Register

This block is the clocked capture stage on the command and address path of a registered memory module. Each rising clock edge it takes the controller's command word and passes it on, one cycle later, towards the DRAM devices. The word has two groups. The first holds 22 bits: 16 address lines, 3 bank lines and the row strobe, column strobe and write-enable strobe. The second holds the two active-low chip selects, clock enable and on-die termination.

To save switching power, the 22-bit group loads only on edges where at least one chip select is asserted (low). When no rank is selected the outputs hold their previous values. A gating-enable input turns this saving off, so that every register loads on every edge. The second group ignores gating and loads on every edge. A one-bit command-valid output marks each cycle whose 22-bit outputs were freshly captured, so that a downstream parity checker can line up with them. A synchronous active-high reset clears every register.

Top module: `csgated_cmd_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every output after that edge is zero, including `cmd_vld_o`.
- R2: Reset takes priority over loading: with `rst` high, the outputs read zero even when gating is enabled, a chip select is low and the inputs are nonzero.
- R3: With `gate_en_i` high and at least one bit of `cs_n_i` low at a rising edge, `addr_o`, `bank_o`, `ras_n_o`, `cas_n_o` and `we_n_o` show the values their inputs had at that edge.
- R4: With `gate_en_i` high and both bits of `cs_n_i` high at a rising edge, the 22 gated outputs keep their previous values whatever the gated inputs carry.
- R5: With `gate_en_i` low at a rising edge, the 22 gated outputs take their input values at that edge for every value of `cs_n_i`.
- R6: `cs_n_o`, `cke_o` and `odt_o` take the values `cs_n_i`, `cke_i` and `odt_i` had at every rising edge outside reset, whatever `gate_en_i` is.
- R7: `cmd_vld_o` is 1 in the cycle after an edge at which the gated group loaded (R3 or R5) and 0 after an edge at which it held (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en_i | input | 1 | 1: gated group loads only on chip select; 0: it loads every edge |
| cs_n_i | input | 2 | Active-low chip selects |
| addr_i | input | 16 | Address in |
| bank_i | input | 3 | Bank address in |
| ras_n_i | input | 1 | Row strobe in, active low |
| cas_n_i | input | 1 | Column strobe in, active low |
| we_n_i | input | 1 | Write enable in, active low |
| cke_i | input | 1 | Clock enable in |
| odt_i | input | 1 | On-die termination in |
| cs_n_o | output | 2 | Registered chip selects |
| addr_o | output | 16 | Registered address |
| bank_o | output | 3 | Registered bank address |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write enable |
| cke_o | output | 1 | Registered clock enable |
| odt_o | output | 1 | Registered on-die termination |
| cmd_vld_o | output | 1 | 1 when the gated outputs hold a word captured at the last edge |

## Verification
The bench goes through every combination of the gating enable and the two chip selects. For each combination it applies eight different data words built from walking ones and a multiplicative mix. The four chip-select codes separate loading from holding: only the code with both bits high must freeze the gated outputs, and only while gating is on. The ungated group and the valid flag are checked against the same sequence. Resets issued in the middle of the run, with a chip select low and nonzero data present, show that the clear wins over a pending load.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    parameter int ADDR_W = 16;
    parameter int BANK_W = 3;
    parameter int CS_W   = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
    } ca_word_t;

    typedef struct packed {
        logic [CS_W-1:0] cs_n;
        logic            cke;
        logic            odt;
    } ctl_word_t;

    localparam int CA_W  = $bits(ca_word_t);
    localparam int CTL_W = $bits(ctl_word_t);

    function automatic logic any_selected(input logic [CS_W-1:0] cs_n);
        return ~(&cs_n);
    endfunction
endpackage

// File: rtl/cmdreg_gate.sv
module cmdreg_gate
    import cmdreg_pkg::*;
(
    input  logic            gate_en,
    input  logic [CS_W-1:0] cs_n,
    output logic            load
);
    always_comb begin
        load = (!gate_en) || any_selected(cs_n);
    end
endmodule

// File: rtl/cmdreg_ca_stage.sv
module cmdreg_ca_stage
    import cmdreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ca_word_t d,
    output ca_word_t q,
    output logic     vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= load;
            if (load) begin
                q <= d;
            end
        end
    end

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0 && !vld));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    assert_vld_set_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> vld);

    assert_vld_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> !vld);
endmodule

// File: rtl/cmdreg_ctl_stage.sv
module cmdreg_ctl_stage
    import cmdreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_word_t d,
    output ctl_word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_ctl_follow_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));

    assert_ctl_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/csgated_cmd_reg.sv
module csgated_cmd_reg
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gate_en_i,
    input  logic [CS_W-1:0]   cs_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic              cke_i,
    input  logic              odt_i,
    output logic [CS_W-1:0]   cs_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              cke_o,
    output logic              odt_o,
    output logic              cmd_vld_o
);
    logic      load;
    ca_word_t  ca_d, ca_q;
    ctl_word_t ctl_d, ctl_q;

    always_comb begin
        ca_d.addr  = addr_i;
        ca_d.bank  = bank_i;
        ca_d.ras_n = ras_n_i;
        ca_d.cas_n = cas_n_i;
        ca_d.we_n  = we_n_i;
        ctl_d.cs_n = cs_n_i;
        ctl_d.cke  = cke_i;
        ctl_d.odt  = odt_i;
    end

    cmdreg_gate u_gate (
        .gate_en (gate_en_i),
        .cs_n    (cs_n_i),
        .load    (load)
    );

    cmdreg_ca_stage u_ca (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (ca_d),
        .q    (ca_q),
        .vld  (cmd_vld_o)
    );

    cmdreg_ctl_stage u_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_d),
        .q   (ctl_q)
    );

    assign addr_o  = ca_q.addr;
    assign bank_o  = ca_q.bank;
    assign ras_n_o = ca_q.ras_n;
    assign cas_n_o = ca_q.cas_n;
    assign we_n_o  = ca_q.we_n;
    assign cs_n_o  = ctl_q.cs_n;
    assign cke_o   = ctl_q.cke;
    assign odt_o   = ctl_q.odt;

    assert_ungated_R5: assert property (@(posedge clk) disable iff (rst)
        !gate_en_i |=> (addr_o == $past(addr_i) && bank_o == $past(bank_i)
                        && we_n_o == $past(we_n_i)));

    assert_reset_wins_R2: assert property (@(posedge clk)
        (rst && gate_en_i && !cs_n_i[0]) |=> (addr_o == '0 && !cmd_vld_o));

    assert_select_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_en_i && (&cs_n_i)) |=> ($stable(addr_o) && $stable(bank_o)
                                      && $stable(ras_n_o) && $stable(cas_n_o)));
endmodule

// File: tb/csgated_cmd_reg_tb.sv
module csgated_cmd_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate_en_i = 1'b1;
    logic [1:0]  cs_n_i = 2'b11;
    logic [15:0] addr_i = '0;
    logic [2:0]  bank_i = '0;
    logic        ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic        cke_i = 1'b0, odt_i = 1'b0;
    logic [1:0]  cs_n_o;
    logic [15:0] addr_o;
    logic [2:0]  bank_o;
    logic        ras_n_o, cas_n_o, we_n_o, cke_o, odt_o, cmd_vld_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [21:0] exp_ca  = '0;
    logic [3:0]  exp_ctl = '0;
    logic        exp_vld = 1'b0;

    always #5 clk = ~clk;

    csgated_cmd_reg dut_i (
        .clk(clk), .rst(rst), .gate_en_i(gate_en_i), .cs_n_i(cs_n_i),
        .addr_i(addr_i), .bank_i(bank_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
        .we_n_i(we_n_i), .cke_i(cke_i), .odt_i(odt_i),
        .cs_n_o(cs_n_o), .addr_o(addr_o), .bank_o(bank_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .cke_o(cke_o), .odt_o(odt_o),
        .cmd_vld_o(cmd_vld_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step(input string tag, input string vtag);
        logic [21:0] in_ca;
        logic [3:0]  in_ctl;
        in_ca  = {addr_i, bank_i, ras_n_i, cas_n_i, we_n_i};
        in_ctl = {cs_n_i, cke_i, odt_i};
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            exp_ca = '0; exp_ctl = '0; exp_vld = 1'b0;
        end else begin
            exp_ctl = in_ctl;
            if (!gate_en_i || !(&cs_n_i)) begin
                exp_ca = in_ca; exp_vld = 1'b1;
            end else begin
                exp_vld = 1'b0;
            end
        end
        check(tag, {10'd0, addr_o, bank_o, ras_n_o, cas_n_o, we_n_o}, {10'd0, exp_ca});
        check(rst ? tag : "R6", {28'd0, cs_n_o, cke_o, odt_o}, {28'd0, exp_ctl});
        check(vtag, {31'd0, cmd_vld_o}, {31'd0, exp_vld});
    endtask

    initial begin
        @(negedge clk);
        step("R1", "R1");
        rst = 1'b0;
        for (int g = 1; g >= 0; g--) begin
            for (int c = 0; c < 4; c++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [15:0] mix;
                    mix = (16'h1 << ((c * 8 + k) % 16)) ^ (16'((g * 32 + c * 8 + k) * 40503));
                    gate_en_i = g[0];
                    cs_n_i    = c[1:0];
                    addr_i    = mix;
                    bank_i    = mix[2:0] ^ 3'(k);
                    ras_n_i   = mix[5];
                    cas_n_i   = mix[9];
                    we_n_i    = mix[13] ^ k[0];
                    cke_i     = k[1];
                    odt_i     = k[2] ^ c[0];
                    if (g == 0)      step("R5", "R7");
                    else if (c == 3) step("R4", "R7");
                    else             step("R3", "R7");
                end
                if (c == 1) begin
                    rst = 1'b1;
                    gate_en_i = 1'b1; cs_n_i = 2'b10; addr_i = 16'hbeef; bank_i = 3'd5;
                    cke_i = 1'b1; odt_i = 1'b1;
                    step("R2", "R2");
                    rst = 1'b0;
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule